// File: doc/BRIEF.md
# Memory-Mapped MSI Receive Decoder

This block sits on a memory-mapped bus where each interrupt context owns one 4 KiB page. It receives 32-bit accesses. A message-signalled interrupt arrives as a write to the first word of a context's page, and the data word carries the interrupt identity. When that write is valid, the block emits a registered set-pending pulse together with the context index and the identity. A downstream interrupt file stores the pending bits and makes the priority choice.

Reads are accepted and always return zero. An access that is not word-aligned, or whose address lies past the last page, is dropped and reported by a one-cycle error pulse. A well-formed write to any other word of a page is ignored without an error. So is a write whose data is not a usable identity.

Top module: `msi_rx_decoder`

## Requirements
- R1: An aligned, in-range write at page offset 0 whose data is in 1..NUM_IDS-1 raises setPend for exactly the cycle after the access cycle, with setId equal to the data.
- R2: With a set-pending pulse, setCtx equals the access address shifted right by 12 (the page shift), and it is always below NUM_CTX.
- R3: A write at page offset 0 whose data is 0, or is NUM_IDS or larger, produces no set-pending pulse and no error.
- R4: An aligned, in-range write at any page offset other than 0, including offset 4, produces no set-pending pulse and no error.
- R5: An access whose address bits [1:0] are not 00 raises errFlag for one cycle after the access, with no set-pending pulse and no read response.
- R6: An aligned access at an address of NUM_CTX*4096 or above raises errFlag for one cycle after the access, with no set-pending pulse and no read response.
- R7: An aligned, in-range read raises rdValid for one cycle after the access, with rdData equal to zero.
- R8: After reset and in every idle cycle, setPend, rdValid and errFlag are low. At most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access present this cycle (always accepted) |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address relative to the region base |
| busWdata | input | 32 | Write data |
| rdValid | output | 1 | Read response pulse |
| rdData | output | 32 | Read data (always zero) |
| errFlag | output | 1 | Rejected-access pulse |
| setPend | output | 1 | Set-pending strobe |
| setCtx | output | CTX_W | Context index for the strobe |
| setId | output | ID_W | Identity for the strobe |

## Verification
A decode fault appears at the ports one cycle after the offending access. It can show as a pulse on the wrong one of the three outputs, as a missing pulse, or as a strobe carrying the wrong context or identity. The bench sweeps every page plus one page past the end. For each page it tries aligned, misaligned and non-zero offsets, with identities at and around both range edges. It checks all outputs in the single cycle where the response must appear, so any misclassification is caught on the access that causes it.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  typedef struct packed {
    logic doPend;
    logic doRead;
    logic doErr;
  } msiCtrl_t;
endpackage

// File: rtl/msi_rx_ctrl.sv
module msi_rx_ctrl
  import msi_rx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_CTX    = 4,
  parameter int NUM_IDS    = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output msiCtrl_t          ctrl
);
  localparam logic [ADDR_W:0] REGION_BYTES = (ADDR_W+1)'(NUM_CTX) << PAGE_SHIFT;
  localparam logic [32:0]     ID_LIMIT     = 33'(NUM_IDS);

  logic aligned, inRange, pageBase, idOk, bad;

  always_comb begin
    aligned  = (busAddr[1:0] == 2'b00);
    inRange  = ({1'b0, busAddr} < REGION_BYTES);
    pageBase = (busAddr[PAGE_SHIFT-1:0] == '0);
    idOk     = (busWdata != 32'd0) && ({1'b0, busWdata} < ID_LIMIT);
    bad      = !aligned || !inRange;
    ctrl.doErr  = busValid && bad;
    ctrl.doRead = busValid && !bad && !busWrite;
    ctrl.doPend = busValid && !bad && busWrite && pageBase && idOk;
  end
endmodule

// File: rtl/msi_rx_dpath.sv
module msi_rx_dpath
  import msi_rx_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int NUM_IDS = 64,
  parameter int CTX_W   = 2,
  parameter int ID_W    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  msiCtrl_t         ctrl,
  input  logic [CTX_W-1:0] ctxIn,
  input  logic [ID_W-1:0]  idIn,
  input  logic             wrSeen,
  output logic             rdValid,
  output logic [31:0]      rdData,
  output logic             errFlag,
  output logic             setPend,
  output logic [CTX_W-1:0] setCtx,
  output logic [ID_W-1:0]  setId
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      errFlag <= 1'b0;
      setPend <= 1'b0;
      setCtx  <= '0;
      setId   <= '0;
    end else begin
      rdValid <= ctrl.doRead;
      errFlag <= ctrl.doErr;
      setPend <= ctrl.doPend;
      rdData  <= '0;
      if (ctrl.doPend) begin
        setCtx <= ctxIn;
        setId  <= idIn;
      end
    end
  end

  // Response pulses are mutually exclusive.
  assert_one_response_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({setPend, rdValid, errFlag}));

  // A strobe never carries identity zero or one past the table.
  assert_id_in_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    setPend |-> (setId != '0) && (int'(setId) < NUM_IDS));

  // The context index of a strobe names an existing page.
  assert_ctx_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    setPend |-> (int'(setCtx) < NUM_CTX));

  // A strobe only follows a write.
  assert_pend_from_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.doPend |-> wrSeen);
endmodule

// File: rtl/msi_rx_decoder.sv
module msi_rx_decoder
  import msi_rx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_CTX    = 4,
  parameter int NUM_IDS    = 64,
  parameter int PAGE_SHIFT = 12,
  localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1,
  localparam int ID_W      = $clog2(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic              errFlag,
  output logic              setPend,
  output logic [CTX_W-1:0]  setCtx,
  output logic [ID_W-1:0]   setId
);
  msiCtrl_t ctrl;

  msi_rx_ctrl #(
    .ADDR_W(ADDR_W), .NUM_CTX(NUM_CTX), .NUM_IDS(NUM_IDS), .PAGE_SHIFT(PAGE_SHIFT)
  ) uCtrl (
    .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .ctrl(ctrl)
  );

  msi_rx_dpath #(
    .NUM_CTX(NUM_CTX), .NUM_IDS(NUM_IDS), .CTX_W(CTX_W), .ID_W(ID_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .ctxIn(busAddr[PAGE_SHIFT +: CTX_W]), .idIn(busWdata[ID_W-1:0]),
    .wrSeen(busValid && busWrite),
    .rdValid(rdValid), .rdData(rdData), .errFlag(errFlag),
    .setPend(setPend), .setCtx(setCtx), .setId(setId)
  );
endmodule

// File: tb/tb_msi_rx_decoder.sv
module tb_msi_rx_decoder;
  localparam int NUM_CTX = 4;
  localparam int NUM_IDS = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic rdValid, errFlag, setPend;
  logic [31:0] rdData;
  logic [1:0] setCtx;
  logic [5:0] setId;

  int nChecks = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  msi_rx_decoder #(.NUM_CTX(NUM_CTX), .NUM_IDS(NUM_IDS)) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .rdValid(rdValid), .rdData(rdData),
    .errFlag(errFlag), .setPend(setPend), .setCtx(setCtx), .setId(setId));

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idleCheck(input string req);
    check(!setPend && !rdValid && !errFlag, req, "idle outputs",
          {setPend, rdValid, errFlag}, 0);
  endtask

  task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] data);
    bit aligned, inRange, bad, expPend, expRd, expErr;
    string req;
    aligned = (addr[1:0] == 2'b00);
    inRange = (addr < 32'(NUM_CTX * 4096));
    bad     = !aligned || !inRange;
    expErr  = bad;
    expRd   = !wr && !bad;
    expPend = wr && !bad && (addr[11:0] == 12'd0) && (data != 0) && (data < NUM_IDS);
    if (!aligned) req = "R5";
    else if (!inRange) req = "R6";
    else if (!wr) req = "R7";
    else if (addr[11:0] != 0) req = "R4";
    else if (expPend) req = "R1";
    else req = "R3";
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busWdata = data;
    @(negedge clk);
    busValid = 1'b0;
    check({setPend, rdValid, errFlag} == {expPend, expRd, expErr}, req,
          "pend/rd/err", {setPend, rdValid, errFlag}, {expPend, expRd, expErr});
    if (expPend) begin
      check(setId == data[5:0], "R1", "setId", setId, data[5:0]);
      check(32'(setCtx) == (addr >> 12), "R2", "setCtx", setCtx, addr >> 12);
    end
    if (expRd) check(rdData == 0, "R7", "rdData", rdData, 0);
    @(negedge clk);
    idleCheck("R8");
  endtask

  initial begin
    #(5 * 200000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] offs [7];
    logic [31:0] datas [8];
    offs  = '{32'h0, 32'h1, 32'h2, 32'h3, 32'h4, 32'h8, 32'hFFC};
    datas = '{32'd0, 32'd1, 32'd5, 32'd62, 32'd63, 32'd64, 32'd65, 32'h8000_0001};
    repeat (3) @(negedge clk);
    idleCheck("R8");
    rstN = 1'b1;
    @(negedge clk);
    idleCheck("R8");
    for (int p = 0; p <= NUM_CTX; p++)
      for (int o = 0; o < 7; o++) begin
        for (int d = 0; d < 8; d++) access(1'b1, 32'(p) * 32'h1000 + offs[o], datas[d]);
        access(1'b0, 32'(p) * 32'h1000 + offs[o], 32'h0);
      end
    access(1'b1, 32'hFFFF_F000, 32'd7);   // R6 far out of range
    access(1'b1, 32'h0000_3000, 32'd63);  // R2 last page, top id
    // back-to-back strobes on two pages
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 32'h1000; busWdata = 32'd9;
    @(negedge clk);
    busAddr = 32'h2000; busWdata = 32'd17;
    check(setPend && setCtx == 2'd1 && setId == 6'd9, "R1", "first b2b",
          {setPend, setCtx, setId}, {1'b1, 2'd1, 6'd9});
    @(negedge clk);
    busValid = 1'b0;
    check(setPend && setCtx == 2'd2 && setId == 6'd17, "R2", "second b2b",
          {setPend, setCtx, setId}, {1'b1, 2'd2, 6'd17});
    @(negedge clk);
    idleCheck("R8");
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule